// File: doc/BRIEF.md
# Power-on and Manual Reset Arbiter

This block takes two active-low reset request pins: a power-on request and a manual request. It brings both into the system clock domain and qualifies each one with a minimum low time. It then decides which kind of reset applies and drives two independent reset outputs. One output resets the CPU core and the other resets the on-chip peripheral modules. A power-on reset drives both outputs. A manual reset drives only the CPU output, so peripheral functions such as memory refresh keep running.

A manual request that is accepted while a bus cycle is in progress is held pending until the bus reports idle. The bus cycle is therefore never cut short. A power-on request overrides a pending or active manual reset at once. When the requesting pin returns high, the block ends the reset and gives a downstream exception sequencer a one-cycle start pulse together with a registered code for the reset type. The block has its own reset input, `rst_n`, which only gives its registers a defined starting state.

Top module: `rst_kind_ctrl`

## Requirements
- R1: After `rst_n` is released, `cpu_rst_n` and `periph_rst_n` are 1, `rst_kind` is 2'b00 and `rst_start` is 0.
- R2: `por_req_n` is accepted once it has been low for at least MIN_LOW (default 20) clock cycles after a two-flop synchronizer. Once it is accepted, both `cpu_rst_n` and `periph_rst_n` go low and `rst_kind` becomes 2'b01.
- R3: `mr_req_n` is accepted only while `por_req_n` is high and `mr_req_n` has been low for at least MIN_LOW cycles. Once it is accepted, `cpu_rst_n` goes low, `periph_rst_n` stays high, and `rst_kind` becomes 2'b10.
- R4: A low pulse shorter than MIN_LOW cycles on either pin has no effect. Neither reset output goes low, no `rst_start` pulse occurs, and the pulse's partial count is discarded.
- R5: When both pins are low together, the power-on reset wins and the result is reported as type 2'b01.
- R6: If a manual request is accepted while `bus_busy` is 1, `cpu_rst_n` stays high until `bus_busy` has been observed at 0.
- R7: A qualified power-on request that arrives while a manual reset is pending behind a busy bus takes effect without waiting for `bus_busy` to fall.
- R8: When the pin of the active reset returns high, both reset outputs are released together with a one-cycle `rst_start` pulse. During that pulse `rst_kind` holds the type of the reset that just ended (never 2'b11).
- R9: `periph_rst_n` is never low while `cpu_rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for the block's own registers |
| por_req_n | input | 1 | Power-on reset request pin, active low, asynchronous |
| mr_req_n | input | 1 | Manual reset request pin, active low, asynchronous |
| bus_busy | input | 1 | High while a bus cycle is in progress |
| cpu_rst_n | output | 1 | Active-low reset to the CPU core |
| periph_rst_n | output | 1 | Active-low reset to the on-chip peripherals |
| rst_kind | output | 2 | Type of the last accepted reset: 00 none, 01 power-on, 10 manual |
| rst_start | output | 1 | One-cycle pulse when the active reset is released |

## Verification
The assertions assume that `bus_busy` is a synchronous input that is stable at each rising edge. They also assume that a manual reset only starts from a cycle in which `bus_busy` was low. The bench therefore changes `bus_busy` and both request pins only on falling clock edges, well away from the sampling edge. It holds each pin low for runs that are clearly above or below the 20-cycle threshold, apart from the deliberate 19-cycle cases. The bench never depends on exactly which cycle the synchronizer lets a change through. It checks reset levels only well inside a low period, and it checks pulses through the scoreboard, which is independent of latency.

// File: rtl/rst_kind_ctrl.sv
module rst_kind_ctrl #(
  parameter int MIN_LOW     = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_req_n,
  input  logic       mr_req_n,
  input  logic       bus_busy,
  output logic       cpu_rst_n,
  output logic       periph_rst_n,
  output logic [1:0] rst_kind,
  output logic       rst_start
);

  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_LOW);

  typedef enum logic [1:0] {S_IDLE, S_MR_WAIT, S_MR_ACT, S_POR_ACT} state_t;

  logic [SYNC_STAGES-1:0] por_sh, mr_sh;
  logic                   por_s, mr_s;
  logic [CW-1:0]          por_cnt, mr_cnt;
  logic                   por_ok, mr_ok;
  state_t                 st, nx;

  assign por_s  = por_sh[SYNC_STAGES-1];
  assign mr_s   = mr_sh[SYNC_STAGES-1];
  assign por_ok = (por_cnt == CMAX);
  assign mr_ok  = (mr_cnt == CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_sh <= '1;
      mr_sh  <= '1;
    end else begin
      por_sh <= {por_sh[SYNC_STAGES-2:0], por_req_n};
      mr_sh  <= {mr_sh[SYNC_STAGES-2:0], mr_req_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_cnt <= '0;
      mr_cnt  <= '0;
    end else begin
      if (por_s)       por_cnt <= '0;
      else if (!por_ok) por_cnt <= por_cnt + 1'b1;
      if (mr_s || !por_s) mr_cnt <= '0;
      else if (!mr_ok)    mr_cnt <= mr_cnt + 1'b1;
    end
  end

  always_comb begin
    nx = st;
    case (st)
      S_IDLE:    if (por_ok) nx = S_POR_ACT;
                 else if (mr_ok) nx = bus_busy ? S_MR_WAIT : S_MR_ACT;
      S_MR_WAIT: if (por_ok) nx = S_POR_ACT;
                 else if (!bus_busy) nx = S_MR_ACT;
      S_MR_ACT:  if (por_ok) nx = S_POR_ACT;
                 else if (mr_s) nx = S_IDLE;
      S_POR_ACT: if (por_s) nx = S_IDLE;
      default:   nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rst_kind  <= 2'b00;
      rst_start <= 1'b0;
    end else begin
      st        <= nx;
      rst_start <= (st == S_MR_ACT || st == S_POR_ACT) && nx == S_IDLE;
      if (nx == S_POR_ACT && st != S_POR_ACT)     rst_kind <= 2'b01;
      else if (nx == S_MR_ACT && st != S_MR_ACT) rst_kind <= 2'b10;
    end
  end

  assign cpu_rst_n    = !(st == S_MR_ACT || st == S_POR_ACT);
  assign periph_rst_n = (st != S_POR_ACT);

endmodule

module rst_kind_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_busy,
  input logic       cpu_rst_n,
  input logic       periph_rst_n,
  input logic [1:0] rst_kind,
  input logic       rst_start
);

  p_periph_needs_cpu_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_rst_n |-> !cpu_rst_n);

  p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_start |=> !rst_start);

  p_start_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_start |-> (rst_kind == 2'b01 || rst_kind == 2'b10));

  p_kind_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_kind != 2'b11);

  p_cpu_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n) |-> rst_start);

  p_por_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(periph_rst_n) |-> (rst_start && rst_kind == 2'b01));

  p_mr_waits_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cpu_rst_n) && periph_rst_n) |-> !$past(bus_busy));

  p_mr_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rst_n && periph_rst_n) |-> rst_kind == 2'b10);

endmodule

bind rst_kind_ctrl rst_kind_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_busy     (bus_busy),
  .cpu_rst_n    (cpu_rst_n),
  .periph_rst_n (periph_rst_n),
  .rst_kind     (rst_kind),
  .rst_start    (rst_start)
);

// File: tb/tb_rst_kind_ctrl.sv
module tb_rst_kind_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_req_n = 1'b1, mr_req_n = 1'b1, bus_busy = 1'b0;
  logic       cpu_rst_n, periph_rst_n, rst_start;
  logic [1:0] rst_kind;

  int n_cmp = 0, n_bad = 0;

  typedef struct packed {
    logic [1:0] kind;
    logic       per;
  } exp_t;

  exp_t exp_q[$];
  logic saw_cpu = 1'b0, saw_per = 1'b0;

  always #10 clk = ~clk;

  rst_kind_ctrl dut (
    .clk(clk), .rst_n(rst_n), .por_req_n(por_req_n), .mr_req_n(mr_req_n),
    .bus_busy(bus_busy), .cpu_rst_n(cpu_rst_n), .periph_rst_n(periph_rst_n),
    .rst_kind(rst_kind), .rst_start(rst_start)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [1:0] k, input logic p);
    exp_t e;
    e.kind = k;
    e.per  = p;
    exp_q.push_back(e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_start) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected start pulse", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rst_kind == e.kind, "R8 reset type on start", rst_kind, e.kind);
          check(saw_cpu == 1'b1, "R8 cpu reset seen", saw_cpu, 1);
          check(saw_per == e.per, "R3 peripheral reset seen", saw_per, e.per);
        end
        saw_cpu = 1'b0;
        saw_per = 1'b0;
      end else begin
        if (!cpu_rst_n)    saw_cpu = 1'b1;
        if (!periph_rst_n) saw_per = 1'b1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int lows;
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    // R1
    check(cpu_rst_n == 1'b1, "R1 cpu_rst_n", cpu_rst_n, 1);
    check(periph_rst_n == 1'b1, "R1 periph_rst_n", periph_rst_n, 1);
    check(rst_kind == 2'b00, "R1 rst_kind", rst_kind, 0);
    check(rst_start == 1'b0, "R1 rst_start", rst_start, 0);

    // R2 power-on reset
    push(2'b01, 1'b1);
    por_req_n = 1'b0;
    cycles(30);
    check(periph_rst_n == 1'b0, "R2 periph low", periph_rst_n, 0);
    check(cpu_rst_n == 1'b0, "R2 cpu low", cpu_rst_n, 0);
    check(rst_kind == 2'b01, "R2 kind", rst_kind, 1);
    por_req_n = 1'b1;
    cycles(10);

    // R3 manual reset, bus idle
    push(2'b10, 1'b0);
    mr_req_n = 1'b0;
    cycles(30);
    check(cpu_rst_n == 1'b0, "R3 cpu low", cpu_rst_n, 0);
    check(periph_rst_n == 1'b1, "R3 periph high", periph_rst_n, 1);
    check(rst_kind == 2'b10, "R3 kind", rst_kind, 2);
    mr_req_n = 1'b1;
    cycles(10);

    // R4 short pulses (19 cycles)
    lows = 0;
    mr_req_n = 1'b0;
    for (int i = 0; i < 19; i++) begin
      @(negedge clk);
      if (!cpu_rst_n) lows++;
    end
    mr_req_n = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!cpu_rst_n) lows++;
    end
    check(lows == 0, "R4 short manual pulse ignored", lows, 0);
    lows = 0;
    por_req_n = 1'b0;
    for (int i = 0; i < 19; i++) begin
      @(negedge clk);
      if (!cpu_rst_n || !periph_rst_n) lows++;
    end
    por_req_n = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!cpu_rst_n || !periph_rst_n) lows++;
    end
    check(lows == 0, "R4 short power-on pulse ignored", lows, 0);
    // R4 counter cleared: 15 + 15 split low must not accept
    lows = 0;
    mr_req_n = 1'b0; cycles(15); mr_req_n = 1'b1; cycles(2);
    mr_req_n = 1'b0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (!cpu_rst_n) lows++;
    end
    mr_req_n = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!cpu_rst_n) lows++;
    end
    check(lows == 0, "R4 partial count discarded", lows, 0);

    // R5 both pins low
    push(2'b01, 1'b1);
    por_req_n = 1'b0;
    mr_req_n  = 1'b0;
    cycles(30);
    check(periph_rst_n == 1'b0, "R5 power-on wins", periph_rst_n, 0);
    por_req_n = 1'b1;
    mr_req_n  = 1'b1;
    cycles(10);

    // R6 manual reset held off by busy bus
    push(2'b10, 1'b0);
    bus_busy = 1'b1;
    mr_req_n = 1'b0;
    cycles(40);
    check(cpu_rst_n == 1'b1, "R6 cpu held off while busy", cpu_rst_n, 1);
    bus_busy = 1'b0;
    cycles(3);
    check(cpu_rst_n == 1'b0, "R6 cpu low after bus idle", cpu_rst_n, 0);
    check(periph_rst_n == 1'b1, "R6 periph untouched", periph_rst_n, 1);
    mr_req_n = 1'b1;
    cycles(10);

    // R7 power-on overrides pending manual
    push(2'b01, 1'b1);
    bus_busy = 1'b1;
    mr_req_n = 1'b0;
    cycles(30);
    check(cpu_rst_n == 1'b1, "R7 manual pending", cpu_rst_n, 1);
    por_req_n = 1'b0;
    cycles(30);
    check(periph_rst_n == 1'b0, "R7 power-on despite busy", periph_rst_n, 0);
    check(cpu_rst_n == 1'b0, "R7 cpu low", cpu_rst_n, 0);
    por_req_n = 1'b1;
    mr_req_n  = 1'b1;
    bus_busy  = 1'b0;
    cycles(10);

    check(exp_q.size() == 0, "R8 all starts seen", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule